// File: doc/BRIEF.md
# Key-protected system control register file

This block is a 32-bit register file for system control. It sits on a simple register bus with one shared word address, a write strobe with write data, and a read strobe with read data. It holds clock, reset, pin-mux, scratch, strap and revision words. Each word takes a fixed value at reset, except the revision word, the two strap words and the key flag, which load from input ports. A two-state lock machine guards a fixed address window. The machine has the states `LK_CLOSED` and `LK_OPEN`. A write of the magic word to offset 0x000 takes the `UNLOCK` transition from closed to open. Any other value written there takes the `RELOCK` transition from open to closed. The stored flag can be read back in bit 0.

Writes are checked in a fixed order: out of range first, then locked, then read-only. A legal write then follows the rule for its target word. The block also has a pseudo-random data word that steps on every read, and a write-only wake-up word. A `variant_new` strap selects between an older and a newer register behaviour. With the newer variant, the primary strap word is set through its own offset (0x070) and cleared through the revision offset (0x07C). Every error raises a single-cycle pulse and leaves a held error code.

Top module: `sysctl_regs`

## Requirements
- R1: During reset each word loads its fixed value. Examples: 0x004 = 0xFFCFFEDC, 0x008 = 0xF3F40000, 0x040 = 0x000000C0, 0x1A4 = 0x00002402. Offset 0x024 loads 0x00000291 on the older variant and 0x93000400 on the newer one. Offsets 0x070, 0x0D0 and 0x07C load `strap1_in`, `strap2_in` and `rev_in`, and the key flag loads `key_open_in`. After reset `err_pulse` is 0 and `err_code` is 0.
- R2: A write of 0x1688A8A8 to offset 0x000 sets the key flag to 1. Any other 32-bit value sets it to 0. A read of 0x000 returns the flag in bit 0 with every other bit zero.
- R3: While the flag is 0, a write to any offset from 0x004 through 0x100 is discarded and raises error code 2 (locked).
- R4: Offsets 0x104 and above accept writes whatever the flag holds.
- R5: Writes to 0x014, 0x050 through 0x06C, 0x078, 0x0E0 and 0x0E4 leave the word unchanged and raise error code 3 (read-only).
- R6: With `variant_new` = 1, a write to 0x070 ORs the data into the strap word. A write to 0x07C clears the strap bits that are 1 in the data and leaves the revision word unchanged.
- R7: With `variant_new` = 0, a write to 0x070 replaces the strap word. A write to 0x07C changes nothing and raises error code 3.
- R8: Each read of 0x078 returns the current state of a 32-bit generator and then steps it. The generator starts at 0x5EEDC0DE and steps as next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. The control word at 0x074 has no effect on this.
- R9: An address with bits [1:0] not zero, or at or beyond offset 0x1A8, is out of range. A read there returns 0, a write there is dropped, and either raises error code 1.
- R10: A read of the wake-up word at 0x0C0 returns the stored value and raises error code 4 (write-only read).
- R11: `err_pulse` is high for exactly one cycle per erroneous access. `err_code` keeps its last value until the next error. When a read and a write in the same cycle both err, the write's code is reported.
- R12: `rd_data` is valid the cycle after `rd_en` and holds otherwise. A read in the same cycle as a write to the same address returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_new | input | 1 | Selects the newer register behaviour (static strap) |
| strap1_in | input | 32 | Reset value of the primary strap word |
| strap2_in | input | 32 | Reset value of the secondary strap word |
| rev_in | input | 32 | Reset value of the revision word |
| key_open_in | input | 1 | Reset value of the key flag |
| addr | input | 12 | Byte address shared by reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Held error code: 1 range, 2 locked, 3 read-only, 4 write-only read |

## Verification
A read and a write can land in the same cycle on the shared address. The read must then see the old contents and the error report must favour the write. The bench provokes this by raising both strobes in one cycle in three cases: a scratch word, the key word during a re-lock, and the wake-up word while locked. In the last case the locked-write code 2 must win over the write-only-read code 4, while the read still returns the stored word. Each result is judged at the ports: the read data of that cycle, the pulse and code of that cycle, and a later plain read that shows whether the write took effect.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [31:0] KEY_MAGIC = 32'h1688_A8A8;

    localparam int unsigned IDX_KEY      = 0;
    localparam int unsigned IDX_FREQ_RES = 5;
    localparam int unsigned IDX_SCR_LO   = 20;
    localparam int unsigned IDX_SCR_HI   = 27;
    localparam int unsigned IDX_STRAP    = 28;
    localparam int unsigned IDX_RNG      = 30;
    localparam int unsigned IDX_REV      = 31;
    localparam int unsigned IDX_WAKE     = 48;
    localparam int unsigned IDX_STRAP2   = 52;
    localparam int unsigned IDX_CNT_LO   = 56;
    localparam int unsigned IDX_CNT_HI   = 57;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_RANGE  = 3'd1,
        ERR_LOCKED = 3'd2,
        ERR_RDONLY = 3'd3,
        ERR_WRONLY = 3'd4
    } err_code_e;

    typedef enum logic {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    // Fixed power-on contents per word index; unlisted words reset to zero.
    function automatic logic [31:0] fixed_reset(input int unsigned idx, input logic newer);
        logic [31:0] v;
        v = 32'h0;
        case (idx)
            1:   v = 32'hFFCF_FEDC;
            2:   v = 32'hF3F4_0000;
            3:   v = 32'h19FC_3E8B;
            7:   v = 32'h0002_6108;
            8:   v = 32'h0003_0291;
            9:   v = newer ? 32'h9300_0400 : 32'h0000_0291;
            11:  v = 32'h0000_0010;
            12:  v = 32'h2000_1A03;
            13:  v = 32'h2000_1A03;
            14:  v = 32'h0400_0030;
            15:  v = 32'h0000_0001;
            16:  v = 32'h0000_00C0;
            19:  v = 32'h0000_0023;
            29:  v = 32'h0000_000E;
            33:  v = 32'h0000_F000;
            34:  v = newer ? 32'h0300_0000 : 32'h0100_0000;
            35:  v = newer ? 32'h0000_0000 : 32'h0000_00FF;
            36:  v = 32'h0000_A000;
            39:  v = newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
            41:  v = 32'hFFFF_0000;
            42:  v = 32'h000F_FFFF;
            56:  v = 32'h0000_00FF;
            57:  v = 32'h0000_00FF;
            65:  v = 32'h8000_0000;
            68:  v = 32'h1E60_0000;
            69:  v = 32'hC000_0000;
            88:  v = 32'h0000_1903;
            96:  v = 32'h0000_007B;
            105: v = 32'h0000_2402;
            default: v = 32'h0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 106,
    parameter int unsigned OPEN_BASE = 65,
    localparam int unsigned IDX_W    = ADDR_W - 2,
    localparam int unsigned SLOT_W   = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              variant_new,
    output logic [SLOT_W-1:0] slot,
    output logic              in_range,
    output logic              in_lock_win,
    output logic              is_key,
    output logic              is_ro,
    output logic              is_wo,
    output logic              is_rng,
    output logic              is_strap,
    output logic              is_rev
);
    logic [IDX_W-1:0] idx;
    int unsigned      idx_u;

    always_comb begin
        idx         = addr[ADDR_W-1:2];
        idx_u       = 32'(idx);
        slot        = idx[SLOT_W-1:0];
        in_range    = (addr[1:0] == 2'b00) && (idx_u < NUM_WORDS);
        is_key      = (idx_u == IDX_KEY);
        in_lock_win = !is_key && (idx_u < OPEN_BASE);
        is_rng      = (idx_u == IDX_RNG);
        is_strap    = (idx_u == IDX_STRAP);
        is_rev      = (idx_u == IDX_REV);
        is_wo       = (idx_u == IDX_WAKE);
        is_ro       = (idx_u == IDX_FREQ_RES)
                   || (idx_u >= IDX_SCR_LO && idx_u <= IDX_SCR_HI)
                   || is_rng
                   || (idx_u == IDX_CNT_LO) || (idx_u == IDX_CNT_HI)
                   || (is_rev && !variant_new);
    end
endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
    parameter int unsigned W    = 32,
    parameter logic [W-1:0] SEED = 32'h5EED_C0DE,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    logic fb;

    always_comb fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= {state[W-2:0], fb};
    end

    // R8
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> state != $past(state));
endmodule

// File: rtl/sysctl_lock_fsm.sv
module sysctl_lock_fsm
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_init,
    input  logic        key_wr,
    input  logic [31:0] wr_data,
    output logic        unlocked
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= key_init ? LK_OPEN : LK_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: if (key_wr && wr_data == KEY_MAGIC) state_d = LK_OPEN;   // UNLOCK
            LK_OPEN:   if (key_wr && wr_data != KEY_MAGIC) state_d = LK_CLOSED; // RELOCK
        endcase
    end

    always_comb unlocked = (state_q == LK_OPEN);

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr && wr_data == KEY_MAGIC |=> unlocked);
    // R2
    key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr && wr_data != KEY_MAGIC |=> !unlocked);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 106,
    parameter int unsigned OPEN_BASE = 65,
    parameter logic [31:0] LFSR_SEED = 32'h5EED_C0DE,
    parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_new,
    input  logic [31:0]       strap1_in,
    input  logic [31:0]       strap2_in,
    input  logic [31:0]       rev_in,
    input  logic              key_open_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              err_pulse,
    output logic [2:0]        err_code
);
    localparam int unsigned SLOT_W = $clog2(NUM_WORDS);
    localparam logic [SLOT_W-1:0] STRAP_SLOT  = SLOT_W'(IDX_STRAP);
    localparam logic [SLOT_W-1:0] STRAP2_SLOT = SLOT_W'(IDX_STRAP2);
    localparam logic [SLOT_W-1:0] REV_SLOT    = SLOT_W'(IDX_REV);

    logic [31:0]       regs [NUM_WORDS];
    logic [SLOT_W-1:0] slot;
    logic in_range, in_lock_win, is_key, is_ro, is_wo, is_rng, is_strap, is_rev;
    logic unlocked, key_wr, wr_blocked, wr_ok, rng_adv;
    logic [31:0] rng_q;
    err_code_e   wr_code, rd_code, sel_code;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .OPEN_BASE(OPEN_BASE)
    ) decode_i (
        .addr(addr), .variant_new(variant_new), .slot(slot),
        .in_range(in_range), .in_lock_win(in_lock_win), .is_key(is_key),
        .is_ro(is_ro), .is_wo(is_wo), .is_rng(is_rng),
        .is_strap(is_strap), .is_rev(is_rev)
    );

    sysctl_lock_fsm lock_i (
        .clk(clk), .rst_n(rst_n), .key_init(key_open_in),
        .key_wr(key_wr), .wr_data(wr_data), .unlocked(unlocked)
    );

    sysctl_lfsr #(.W(32), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) rng_i (
        .clk(clk), .rst_n(rst_n), .adv(rng_adv), .state(rng_q)
    );

    always_comb begin
        key_wr     = wr_en && in_range && is_key;
        wr_blocked = in_lock_win && !unlocked;
        wr_ok      = wr_en && in_range && !wr_blocked && !is_ro && !is_key;
        rng_adv    = rd_en && in_range && is_rng;

        if (!wr_en)         wr_code = ERR_NONE;
        else if (!in_range) wr_code = ERR_RANGE;
        else if (wr_blocked) wr_code = ERR_LOCKED;
        else if (is_ro)     wr_code = ERR_RDONLY;
        else                wr_code = ERR_NONE;

        if (!rd_en)         rd_code = ERR_NONE;
        else if (!in_range) rd_code = ERR_RANGE;
        else if (is_wo)     rd_code = ERR_WRONLY;
        else                rd_code = ERR_NONE;

        sel_code = (wr_code != ERR_NONE) ? wr_code : rd_code;
    end

    // Register storage and per-word write rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                regs[i] <= fixed_reset(i, variant_new);
            end
            regs[STRAP_SLOT]  <= strap1_in;
            regs[STRAP2_SLOT] <= strap2_in;
            regs[REV_SLOT]    <= rev_in;
        end else if (wr_ok) begin
            if (is_strap && variant_new)
                regs[STRAP_SLOT] <= regs[STRAP_SLOT] | wr_data;
            else if (is_rev)
                regs[STRAP_SLOT] <= regs[STRAP_SLOT] & ~wr_data;
            else
                regs[slot] <= wr_data;
        end
    end

    // Read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 32'h0;
        end else if (rd_en) begin
            if (!in_range)   rd_data <= 32'h0;
            else if (is_key) rd_data <= {31'h0, unlocked};
            else if (is_rng) rd_data <= rng_q;
            else             rd_data <= regs[slot];
        end
    end

    // Error reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_pulse <= (sel_code != ERR_NONE);
            if (sel_code != ERR_NONE) err_code <= sel_code;
        end
    end

    // R11
    err_pulse_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_code != 3'd0);
    // R9
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_range |=> rd_data == 32'h0);
    // R3
    locked_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range && in_lock_win && !unlocked |=> err_pulse && err_code == 3'd2);
    // R6
    rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range && is_rev |=> regs[REV_SLOT] == $past(regs[REV_SLOT]));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_new = 1'b0;
    logic [31:0] strap1_in = 32'h0, strap2_in = 32'h0, rev_in = 32'h0;
    logic        key_open_in = 1'b0;
    logic [11:0] addr = 12'h0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        err_pulse;
    logic [2:0]  err_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] got_rd;
    logic        got_ep;
    logic [2:0]  got_ec;
    logic [31:0] exp_rng;

    localparam logic [31:0] KEY = 32'h1688_A8A8;

    always #4 clk = ~clk;

    sysctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .variant_new(variant_new),
        .strap1_in(strap1_in), .strap2_in(strap2_in), .rev_in(rev_in),
        .key_open_in(key_open_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .err_pulse(err_pulse), .err_code(err_code)
    );

    function automatic logic [31:0] rng_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic op(input logic r, input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        @(negedge clk);
        got_rd = rd_data; got_ep = err_pulse; got_ec = err_code;
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        op(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a);
        op(1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic do_reset(input logic newer, input logic key0, input logic [31:0] s1,
                            input logic [31:0] s2, input logic [31:0] rv);
        @(negedge clk);
        rst_n = 1'b0; variant_new = newer; key_open_in = key0;
        strap1_in = s1; strap2_in = s2; rev_in = rv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_rng = 32'h5EED_C0DE;
        chk_eq("R1 err_pulse after reset", {31'h0, err_pulse}, 32'h0);
        chk_eq("R1 err_code after reset", {29'h0, err_code}, 32'h0);
    endtask

    task automatic t_reset_old;
        rd(12'h004); chk_eq("R1 0x004", got_rd, 32'hFFCF_FEDC);
        rd(12'h008); chk_eq("R1 0x008", got_rd, 32'hF3F4_0000);
        rd(12'h040); chk_eq("R1 0x040", got_rd, 32'h0000_00C0);
        rd(12'h024); chk_eq("R1 0x024 older", got_rd, 32'h0000_0291);
        rd(12'h070); chk_eq("R1 strap1 load", got_rd, 32'hA5A5_0000);
        rd(12'h0D0); chk_eq("R1 strap2 load", got_rd, 32'h0000_1234);
        rd(12'h07C); chk_eq("R1 rev load", got_rd, 32'h0201_0303);
        rd(12'h000); chk_eq("R1 key flag load", got_rd, 32'h0);
        rd(12'h1A4); chk_eq("R1 0x1A4", got_rd, 32'h0000_2402);
    endtask

    task automatic t_lock;
        wr(12'h044, 32'hAAAA_AAAA);
        chk_eq("R3 locked write code", {28'h0, got_ep, got_ec}, 32'h0000_000A);
        rd(12'h044); chk_eq("R3 locked write dropped", got_rd, 32'h0);
        wr(12'h000, KEY);
        rd(12'h000); chk_eq("R2 unlock flag", got_rd, 32'h1);
        wr(12'h044, 32'hDEAD_BEEF);
        chk_eq("R3 unlocked write no error", {31'h0, got_ep}, 32'h0);
        rd(12'h044); chk_eq("R3 unlocked write lands", got_rd, 32'hDEAD_BEEF);
        wr(12'h000, KEY + 32'h1);
        rd(12'h000); chk_eq("R2 wrong key relocks", got_rd, 32'h0);
        wr(12'h044, 32'h0000_1234);
        chk_eq("R3 relocked write code", {29'h0, got_ec}, 32'h2);
        rd(12'h044); chk_eq("R3 relocked write dropped", got_rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_high;
        wr(12'h104, 32'h0BAD_F00D);
        chk_eq("R4 0x104 no error while locked", {31'h0, got_ep}, 32'h0);
        rd(12'h104); chk_eq("R4 0x104 writable while locked", got_rd, 32'h0BAD_F00D);
        wr(12'h100, 32'h0000_0077);
        chk_eq("R3 0x100 locked code", {28'h0, got_ep, got_ec}, 32'h0000_000A);
        rd(12'h100); chk_eq("R3 0x100 boundary dropped", got_rd, 32'h0);
    endtask

    task automatic t_ro;
        wr(12'h000, KEY);
        wr(12'h014, 32'h1);
        chk_eq("R5 0x014 ro code", {28'h0, got_ep, got_ec}, 32'h0000_000B);
        rd(12'h014); chk_eq("R5 0x014 unchanged", got_rd, 32'h0);
        wr(12'h06C, 32'h5);
        chk_eq("R5 0x06C ro code", {29'h0, got_ec}, 32'h3);
        rd(12'h06C); chk_eq("R5 0x06C unchanged", got_rd, 32'h0);
        wr(12'h050, 32'h6);
        rd(12'h050); chk_eq("R5 0x050 unchanged", got_rd, 32'h0);
        wr(12'h0E4, 32'h0);
        chk_eq("R5 0x0E4 ro code", {29'h0, got_ec}, 32'h3);
        rd(12'h0E4); chk_eq("R5 0x0E4 unchanged", got_rd, 32'h0000_00FF);
    endtask

    task automatic t_old_strap;
        wr(12'h070, 32'h0000_1111);
        rd(12'h070); chk_eq("R7 strap overwrite", got_rd, 32'h0000_1111);
        wr(12'h07C, 32'hFFFF_FFFF);
        chk_eq("R7 rev write code", {28'h0, got_ep, got_ec}, 32'h0000_000B);
        rd(12'h07C); chk_eq("R7 rev unchanged", got_rd, 32'h0201_0303);
        rd(12'h070); chk_eq("R7 strap untouched by rev write", got_rd, 32'h0000_1111);
    endtask

    task automatic t_rng;
        rd(12'h078); chk_eq("R8 rng first", got_rd, exp_rng); exp_rng = rng_next(exp_rng);
        rd(12'h078); chk_eq("R8 rng second", got_rd, exp_rng); exp_rng = rng_next(exp_rng);
        wr(12'h074, 32'h0);
        rd(12'h078); chk_eq("R8 rng ignores control", got_rd, exp_rng); exp_rng = rng_next(exp_rng);
        wr(12'h078, 32'h0);
        chk_eq("R5 0x078 ro code", {29'h0, got_ec}, 32'h3);
        rd(12'h078); chk_eq("R8 rng after write", got_rd, exp_rng); exp_rng = rng_next(exp_rng);
    endtask

    task automatic t_range;
        rd(12'h1A8);
        chk_eq("R9 read past end data", got_rd, 32'h0);
        chk_eq("R9 read past end code", {28'h0, got_ep, got_ec}, 32'h0000_0009);
        rd(12'hFFC); chk_eq("R9 read top of region", got_rd, 32'h0);
        rd(12'h042);
        chk_eq("R9 misaligned read", {got_rd[30:0], got_ep}, 32'h1);
        wr(12'h042, 32'h1111_1111);
        chk_eq("R9 misaligned write code", {29'h0, got_ec}, 32'h1);
        rd(12'h040); chk_eq("R9 misaligned write dropped", got_rd, 32'h0000_00C0);
        wr(12'h1A8, 32'h2222_2222);
        chk_eq("R9 write past end code", {28'h0, got_ep, got_ec}, 32'h0000_0009);
    endtask

    task automatic t_wo;
        wr(12'h0C0, 32'h0000_0055);
        chk_eq("R10 wake write no error", {31'h0, got_ep}, 32'h0);
        rd(12'h0C0);
        chk_eq("R10 wake read data", got_rd, 32'h0000_0055);
        chk_eq("R10 wake read code", {28'h0, got_ep, got_ec}, 32'h0000_000C);
    endtask

    task automatic t_pulse;
        wr(12'h000, 32'h0);
        op(1'b1, 1'b1, 12'h0C0, 32'h0000_0099);
        chk_eq("R12 read during locked write", got_rd, 32'h0000_0055);
        chk_eq("R11 write code wins", {28'h0, got_ep, got_ec}, 32'h0000_000A);
        @(negedge clk);
        chk_eq("R11 pulse single cycle", {31'h0, err_pulse}, 32'h0);
        chk_eq("R11 code held", {29'h0, err_code}, 32'h2);
        rd(12'h0C0); chk_eq("R11 locked write dropped", got_rd, 32'h0000_0055);
    endtask

    task automatic t_new_strap;
        rd(12'h024); chk_eq("R1 0x024 newer", got_rd, 32'h9300_0400);
        rd(12'h000); chk_eq("R1 key flag load open", got_rd, 32'h1);
        rd(12'h0D0); chk_eq("R1 strap2 load newer", got_rd, 32'hCAFE_0001);
        wr(12'h070, 32'h0100_0000);
        rd(12'h070); chk_eq("R6 strap OR", got_rd, 32'h01F0_000F);
        wr(12'h07C, 32'h0000_000F);
        chk_eq("R6 rev write accepted", {31'h0, got_ep}, 32'h0);
        rd(12'h070); chk_eq("R6 strap clear via rev", got_rd, 32'h01F0_0000);
        rd(12'h07C); chk_eq("R6 rev unchanged", got_rd, 32'h0403_0303);
    endtask

    task automatic t_same;
        wr(12'h044, 32'h1122_3344);
        op(1'b1, 1'b1, 12'h044, 32'h5566_7788);
        chk_eq("R12 same-cycle read old", got_rd, 32'h1122_3344);
        rd(12'h044); chk_eq("R12 later read new", got_rd, 32'h5566_7788);
        @(negedge clk);
        chk_eq("R12 rd_data holds", rd_data, 32'h5566_7788);
        op(1'b1, 1'b1, 12'h000, 32'h0);
        chk_eq("R2 same-cycle key read old", got_rd, 32'h1);
        rd(12'h000); chk_eq("R2 key relocked", got_rd, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0, 1'b0, 32'hA5A5_0000, 32'h0000_1234, 32'h0201_0303);
        t_reset_old();
        t_lock();
        t_high();
        t_ro();
        t_old_strap();
        t_rng();
        t_range();
        t_wo();
        t_pulse();
        do_reset(1'b1, 1'b1, 32'h00F0_000F, 32'hCAFE_0001, 32'h0403_0303);
        t_new_strap();
        t_same();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule